// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a supervisory timer that counts down and must be restarted ("fed") by software before it reaches zero. It runs from one clock. A tick enable stands in for the slower watchdog clock, and every four ticks take one count off the counter. Software programs three settings: a reload value, a warning compare value and a window limit. It feeds the timer by writing an unlock pair of bytes to a feed register.

A successful feed restarts the counter from the reload value. The counter can never be loaded above the window limit. A feed that completes while the counter is still above the window limit is too early. An early feed counts as a fault and raises the watchdog event output, just as a timeout does. A warning output rises a little before timeout: it fires when the counter's lower bits equal the compare value and all of its upper bits are clear. The live counter is available on an output so that it can be read back.

Software drives the block through a simple write port: a register select, a data word and a write strobe. Register select encoding: 0 = reload value, 1 = feed byte (bits 7:0), 2 = warning compare (bits WARN_W-1:0), 3 = window limit.

Top module: `wwdg_core`

## Requirements
- R1: Reset state: the counter holds 0x0000FF, the reload value is 0x0000FF, the warning compare is 0, the window limit is all ones, the feed sequence is idle, and warn_irq and wdg_event are low.
- R2: Each tick advances a 2-bit divider. The counter drops by one on the tick that wraps the divider from 3 to 0, and only while the counter is non-zero. With tick low and no successful feed, the counter does not change.
- R3: A feed is a write of byte 0xAA to select 1, followed by a write of 0x55 to select 1. If the counter is not above the window limit, the 0x55 write loads the counter at that clock edge and clears the divider. No tick is processed in that cycle.
- R4: A feed-register write that is not 0xAA while idle, or that is not 0x55 directly after a 0xAA, leaves the sequence idle and does not reload. A 0xAA received after a 0xAA also aborts the sequence.
- R5: A warning match is counter[WARN_W-1:0] equal to the compare value while counter bits above WARN_W-1 are zero. On a tick in which the counter matches, warn_irq rises at that edge, so it shows one cycle after the matching count first appears. warn_irq then stays high.
- R6: With the compare value 0, warn_irq and wdg_event rise in the same cycle.
- R7: A tick while the counter is zero sets wdg_event. wdg_event then stays high until reset, even if a later feed succeeds.
- R8: A feed completing while the counter is above the window limit sets wdg_event at that edge and leaves the counter unchanged.
- R9: On a successful feed the counter is loaded with the smaller of the reload value and the window limit.
- R10: A successful feed clears warn_irq.
- R11: Writing select 2 keeps only bits WARN_W-1:0 of the data as the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Watchdog clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 reload, 1 feed, 2 warning, 3 window) |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| warn_irq | output | 1 | Early warning interrupt, sticky until a successful feed |
| wdg_event | output | 1 | Watchdog event, sticky until reset |

## Verification
The bench builds the block with its default parameters: a 24-bit counter, a 10-bit warning compare and a divide-by-four prescaler. Because the counter comes out of reset at 0xFF, a full timeout from reset takes only about a thousand cycles, and the zero-compare case where warning and event coincide is easy to reach. With a window limit of 0x200 and a compare value of 0x1F0, the warning match is reached about sixty ticks after a clamped feed. A window limit of 0x100 then turns the next feed into an early one.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_FEED   = 2'd1,
    SEL_WARN   = 2'd2,
    SEL_WINDOW = 2'd3
  } reg_sel_e;

  typedef enum logic {
    FEED_IDLE  = 1'b0,
    FEED_ARMED = 1'b1
  } feed_st_e;

  localparam logic [7:0] FEED_KEY_A = 8'hAA;
  localparam logic [7:0] FEED_KEY_B = 8'h55;
endpackage

// File: rtl/wwdg_regs.sv
module wwdg_regs
  import wwdg_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int WARN_W     = 10,
  parameter int RST_RELOAD = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  reload_val,
  output logic [WARN_W-1:0] warn_cmp,
  output logic [CNT_W-1:0]  win_lim
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_val <= CNT_W'(RST_RELOAD);
      warn_cmp   <= '0;
      win_lim    <= '1;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_RELOAD: reload_val <= wr_data;
        SEL_WARN:   warn_cmp   <= wr_data[WARN_W-1:0];
        SEL_WINDOW: win_lim    <= wr_data;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/wwdg_feed.sv
module wwdg_feed
  import wwdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_byte,
  output logic       feed_ok
);
  feed_st_e st_q;
  logic     feed_wr;

  assign feed_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_FEED);
  assign feed_ok = feed_wr && (st_q == FEED_ARMED) && (wr_byte == FEED_KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FEED_IDLE;
    end else if (feed_wr) begin
      st_q <= ((st_q == FEED_IDLE) && (wr_byte == FEED_KEY_A)) ? FEED_ARMED : FEED_IDLE;
    end
  end
endmodule

// File: rtl/wwdg_counter.sv
module wwdg_counter #(
  parameter int CNT_W     = 24,
  parameter int WARN_W    = 10,
  parameter int DIV_LOG2  = 2,
  parameter int RST_COUNT = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              feed_ok,
  input  logic [CNT_W-1:0]  reload_val,
  input  logic [WARN_W-1:0] warn_cmp,
  input  logic [CNT_W-1:0]  win_lim,
  output logic [CNT_W-1:0]  count,
  output logic              warn_irq,
  output logic              wdg_event,
  output logic              warn_match,
  output logic              too_early,
  output logic              div_wrap
);
  logic [DIV_LOG2-1:0] div_q;

  function automatic logic match_f(input logic [CNT_W-1:0] c, input logic [WARN_W-1:0] cmp);
    return (c[WARN_W-1:0] == cmp) && (c[CNT_W-1:WARN_W] == '0);
  endfunction

  function automatic logic [CNT_W-1:0] clamp_f(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  assign warn_match = match_f(count, warn_cmp);
  assign too_early  = count > win_lim;
  assign div_wrap   = tick && (div_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= CNT_W'(RST_COUNT);
      div_q     <= '0;
      warn_irq  <= 1'b0;
      wdg_event <= 1'b0;
    end else if (feed_ok) begin
      if (too_early) begin
        wdg_event <= 1'b1;
      end else begin
        count    <= clamp_f(reload_val, win_lim);
        div_q    <= '0;
        warn_irq <= 1'b0;
      end
    end else if (tick) begin
      div_q <= div_q + 1'b1;
      if (div_wrap && (count != '0)) count <= count - 1'b1;
      if (count == '0) wdg_event <= 1'b1;
      if (warn_match) warn_irq <= 1'b1;
    end
  end
endmodule

// File: rtl/wwdg_core.sv
module wwdg_core #(
  parameter int CNT_W    = 24,
  parameter int WARN_W   = 10,
  parameter int DIV_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             warn_irq,
  output logic             wdg_event
);
  localparam int RST_VAL = 255;

  logic [CNT_W-1:0]  reload_val;
  logic [WARN_W-1:0] warn_cmp;
  logic [CNT_W-1:0]  win_lim;
  logic              feed_ok;
  logic              warn_match;
  logic              too_early;
  logic              div_wrap;

  wwdg_regs #(.CNT_W(CNT_W), .WARN_W(WARN_W), .RST_RELOAD(RST_VAL)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .reload_val(reload_val), .warn_cmp(warn_cmp), .win_lim(win_lim)
  );

  wwdg_feed i_feed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_byte(wr_data[7:0]), .feed_ok(feed_ok)
  );

  wwdg_counter #(.CNT_W(CNT_W), .WARN_W(WARN_W), .DIV_LOG2(DIV_LOG2), .RST_COUNT(RST_VAL)) i_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .feed_ok(feed_ok),
    .reload_val(reload_val), .warn_cmp(warn_cmp), .win_lim(win_lim),
    .count(count_o), .warn_irq(warn_irq), .wdg_event(wdg_event),
    .warn_match(warn_match), .too_early(too_early), .div_wrap(div_wrap)
  );
endmodule

// File: rtl/wwdg_checker.sv
module wwdg_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             feed_ok,
  input logic             too_early,
  input logic             warn_match,
  input logic [CNT_W-1:0] win_lim,
  input logic [CNT_W-1:0] count,
  input logic             warn_irq,
  input logic             wdg_event
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !feed_ok) |=> $stable(count)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_ok |=> ((count == $past(count)) || (count == $past(count) - 1'b1))); // R2

  AST_WARN_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && warn_match && !feed_ok) |=> warn_irq); // R5

  AST_EVENT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !feed_ok && (count == '0)) |=> wdg_event); // R7

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_event |=> wdg_event); // R7

  AST_EARLY_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok && too_early) |=> (wdg_event && $stable(count))); // R8

  AST_RELOAD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok && !too_early) |=> (count <= $past(win_lim))); // R9

  AST_FEED_CLEARS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok && !too_early) |=> !warn_irq); // R10
endmodule

bind wwdg_core wwdg_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .feed_ok(feed_ok), .too_early(too_early),
  .warn_match(warn_match), .win_lim(win_lim), .count(count_o),
  .warn_irq(warn_irq), .wdg_event(wdg_event)
);

// File: tb/test_wwdg_core.sv
module test_wwdg_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [23:0] wr_data = '0;
  logic [23:0] count_o;
  logic        warn_irq;
  logic        wdg_event;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wwdg_core i_wwdg_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .count_o(count_o), .warn_irq(warn_irq), .wdg_event(wdg_event)
  );

  // behavioural reference model
  int m_cnt, m_pre, m_reload, m_win, m_cmp;
  bit m_warn, m_ev, m_armed;

  always @(posedge clk) begin
    bit fed;
    int b;
    if (!rst_n) begin
      m_cnt = 255; m_pre = 0; m_reload = 255; m_win = 24'hFFFFFF; m_cmp = 0;
      m_warn = 0; m_ev = 0; m_armed = 0;
    end else begin
      fed = 0;
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_reload = int'(wr_data);
          2'd2: m_cmp = int'(wr_data) % 1024;
          2'd3: m_win = int'(wr_data);
          default: begin
            b = int'(wr_data) % 256;
            if (m_armed) begin fed = (b == 'h55); m_armed = 0; end
            else m_armed = (b == 'hAA);
          end
        endcase
      end
      if (fed) begin
        if (m_cnt > m_win) m_ev = 1;
        else begin
          m_cnt = (m_reload < m_win) ? m_reload : m_win;
          m_pre = 0; m_warn = 0;
        end
      end else if (tick) begin
        if ((m_cnt / 1024 == 0) && (m_cnt % 1024 == m_cmp)) m_warn = 1;
        if (m_cnt == 0) m_ev = 1;
        if (m_pre == 3 && m_cnt > 0) m_cnt = m_cnt - 1;
        m_pre = (m_pre + 1) % 4;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(count_o) == m_cnt, "R2 count vs model", int'(count_o), m_cnt);
      chk(warn_irq == m_warn, "R5 warn vs model", int'(warn_irq), int'(m_warn));
      chk(wdg_event == m_ev, "R7 event vs model", int'(wdg_event), int'(m_ev));
    end
  end

  task automatic wr(input int sel, input int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 24'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic feed();
    wr(1, 'hAA);
    wr(1, 'h55);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(count_o == 24'hFF, "R1 count", int'(count_o), 'hFF);
    chk(!warn_irq && !wdg_event, "R1 outputs", int'({warn_irq, wdg_event}), 0);

    // R2: decrement every fourth tick, hold without tick
    tick = 1'b1;
    repeat (8) @(negedge clk);
    chk(count_o == 24'hFD, "R2 eight ticks", int'(count_o), 'hFD);
    tick = 1'b0;
    c = int'(count_o);
    repeat (5) @(negedge clk);
    chk(int'(count_o) == c, "R2 hold", int'(count_o), c);
    tick = 1'b1;

    // R3: valid feed reloads
    wr(0, 'h80);
    feed();
    chk(count_o == 24'h80, "R3 reload", int'(count_o), 'h80);

    // R4: broken sequences do not reload
    wr(0, 'h300);
    wr(1, 'hAA); wr(1, 'h12); wr(1, 'h55);
    chk(count_o < 24'h80, "R4 abort", int'(count_o), 'h7F);
    wr(1, 'hAA); wr(1, 'hAA); wr(1, 'h55);
    chk(count_o < 24'h80, "R4 double AA", int'(count_o), 'h7F);

    // R9: reload clamped to window
    wr(3, 'h200);
    feed();
    chk(count_o == 24'h200, "R9 clamp", int'(count_o), 'h200);

    // R11 / R5: compare keeps low bits, warning one cycle after match
    wr(2, 'hABC1F0);
    while (count_o != 24'h1F0) @(negedge clk);
    chk(!warn_irq, "R5 not yet", int'(warn_irq), 0);
    @(negedge clk);
    chk(warn_irq, "R11 R5 warn raised", int'(warn_irq), 1);

    // R10: feed clears warning
    feed();
    chk(!warn_irq && count_o == 24'h200, "R10 cleared", int'(warn_irq), 0);

    // R8: early feed
    wr(3, 'h100);
    wr(1, 'hAA);
    c = int'(count_o);
    wr(1, 'h55);
    chk(wdg_event, "R8 event", int'(wdg_event), 1);
    chk(int'(count_o) == c, "R8 no reload", int'(count_o), c);
    repeat (10) @(negedge clk);
    chk(wdg_event, "R7 sticky", int'(wdg_event), 1);

    // R6 / R7: timeout from reset with compare 0
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_o <= 24'hFF && !wdg_event, "R1 after reset", int'(count_o), 'hFF);
    c = 0;
    while (!wdg_event && !warn_irq) @(negedge clk);
    chk(warn_irq && wdg_event, "R6 same cycle", int'({warn_irq, wdg_event}), 3);
    chk(count_o == 0, "R7 zero", int'(count_o), 0);
    feed();
    repeat (5) @(negedge clk);
    chk(wdg_event, "R7 sticky after feed", int'(wdg_event), 1);
    finish_run();
  end
endmodule